// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block is the coherence controller of one private, direct-mapped cache in a small bus-based multiprocessor. For every line it keeps a tag, a data word and one of four states. Modified marks the only copy, which is dirty. Exclusive marks the only cached copy, which is clean. Shared marks one of possibly several clean copies. Invalid marks an empty line. Processor reads and writes that hit are answered locally. A miss, or a write to a shared line, becomes a bus transaction once an external arbiter grants the bus.

The controller also watches the transactions that other caches place on the bus. It answers them by asserting the wired-OR shared line, by supplying or flushing data, and by moving its own copy to Shared or Invalid. When it fills a line after its own read, it samples the shared line to choose between Exclusive and Shared. A dirty line that must be displaced by a conflicting miss is written back before the new request goes out.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready`, `bus_req`, `snp_shared` and `snp_flush` are low, and a snoop to any address draws no response.
- R2: A processor read that hits a valid line raises `cpu_ready` for one cycle, on the clock edge that accepts it, with the stored word on `cpu_rdata`. It raises no bus request. Line index is `addr[IDX_W-1:0]` and the tag is the remaining upper bits.
- R3: A read miss requests the bus with `bus_cmd` = 1 (read) and the missing address. On the granted cycle the line takes `bus_rdata`. It becomes Shared if `bus_shared_in` is high and Exclusive otherwise.
- R4: A write miss requests the bus with `bus_cmd` = 2 (read-exclusive). On grant the line becomes Modified and holds the written word.
- R5: A write to a Shared line issues `bus_cmd` = 2 and the line becomes Modified holding the written word. `bus_rdata` is ignored.
- R6: A write to an Exclusive or Modified line completes like a read hit with no bus request, and leaves the line Modified.
- R7: A snooped read (`snp_cmd` = 1) that hits a valid line raises `snp_shared` one cycle later. A Modified or Exclusive hit also raises `snp_flush` with the line's data on `snp_data`. The line then becomes Shared.
- R8: A snooped read-exclusive (`snp_cmd` = 2) that hits a valid line never raises `snp_shared`. A Modified hit raises `snp_flush` with its data one cycle later. The line becomes Invalid.
- R9: A miss whose line holds Modified data for another tag first issues `bus_cmd` = 3 (write-back) with the old address and data. The fill request follows only after that grant. A clean displaced line causes no write-back.
- R10: A snoop whose tag differs from the indexed line's tag, or that meets an Invalid line, draws no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_ready` |
| bus_req | output | 1 | Request for the shared bus |
| bus_cmd | output | 2 | 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled on own read grant |
| bus_rdata | input | DATA_W | Fill data in the granted cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command: 1 read, 2 read-exclusive |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache's drive onto the shared line |
| snp_flush | output | 1 | This cache supplies data for the snoop |
| snp_data | output | DATA_W | Supplied or flushed data |

## Verification
The hardest situation to reach is a dirty line being displaced, because it takes a write miss to make one line Modified and then a read of another tag at the same index. The bench builds that pair of accesses and records every granted bus transaction in order. It can then check that the write-back carries the old address and data, and that it comes before the fill. Line states cannot be seen directly, so each is revealed afterwards through the ports. A snooped read shows whether the cache asserts the shared line and supplies data. A local write shows whether a read-exclusive transaction goes out.

// File: rtl/mesi_snoop_pkg.sv
package mesi_snoop_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_WBACK = 2'd1, FS_FETCH = 2'd2} fsm_e;
endpackage

// File: rtl/mesi_data_ram.sv
module mesi_data_ram #(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [LINES];

  // one write port, two asynchronous read ports (distributed RAM)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_snoop_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd_en,
  output line_st_e          upd_st,
  output logic              resp_shared,
  output logic              resp_flush,
  output logic [DATA_W-1:0] resp_data
);
  logic hit, is_rd, is_rdx, flush_nxt;

  assign is_rd     = (snp_cmd == CMD_RD);
  assign is_rdx    = (snp_cmd == CMD_RDX);
  assign hit       = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
  assign upd_en    = hit && (is_rd || is_rdx);
  assign upd_st    = is_rdx ? ST_I : ST_S;
  assign flush_nxt = hit && ((line_st == ST_M && (is_rd || is_rdx)) ||
                             (line_st == ST_E && is_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_shared <= 1'b0;
      resp_flush  <= 1'b0;
      resp_data   <= '0;
    end else begin
      resp_shared <= hit && is_rd;
      resp_flush  <= flush_nxt;
      resp_data   <= flush_nxt ? line_data : '0;
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e              fsm_q;
  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];

  logic              rq_we;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;

  logic [IDX_W-1:0]  cpu_idx, rq_idx, snp_idx, ram_ra, ram_wa;
  logic [TAG_W-1:0]  cpu_tag, rq_tag, snp_tag;
  line_st_e          cur_st;
  logic [TAG_W-1:0]  cur_tag;
  logic              cur_hit, accept, fast, fill_now, ram_we, in_idle;
  logic [DATA_W-1:0] ram_wd, rd_a, rd_b;
  logic              snp_upd_en;
  line_st_e          snp_upd_st;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign rq_idx  = rq_addr[IDX_W-1:0];
  assign rq_tag  = rq_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  assign cur_st  = st_q[cpu_idx];
  assign cur_tag = tag_q[cpu_idx];
  assign cur_hit = (cur_st != ST_I) && (cur_tag == cpu_tag);
  assign in_idle = (fsm_q == FS_IDLE);
  // snoops take the cycle: a processor request waits while one is present
  assign accept  = in_idle && cpu_req && !cpu_ready && !snp_valid;
  assign fast    = cur_hit && (!cpu_we || cur_st == ST_M || cur_st == ST_E);
  assign fill_now = (fsm_q == FS_FETCH) && bus_gnt;

  assign ram_ra = in_idle ? cpu_idx : rq_idx;
  assign ram_we = (accept && fast && cpu_we) || fill_now;
  assign ram_wa = accept ? cpu_idx : rq_idx;
  assign ram_wd = accept ? cpu_wdata : (rq_we ? rq_wdata : bus_rdata);

  mesi_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_wa),
    .wdata   (ram_wd),
    .raddr_a (ram_ra),
    .rdata_a (rd_a),
    .raddr_b (snp_idx),
    .rdata_b (rd_b)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk         (clk),
    .rst         (rst),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .snp_tag     (snp_tag),
    .line_st     (st_q[snp_idx]),
    .line_tag    (tag_q[snp_idx]),
    .line_data   (rd_b),
    .upd_en      (snp_upd_en),
    .upd_st      (snp_upd_st),
    .resp_shared (snp_shared),
    .resp_flush  (snp_flush),
    .resp_data   (snp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= FS_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rq_we     <= 1'b0;
      rq_addr   <= '0;
      rq_wdata  <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      cpu_ready <= 1'b0;
      if (snp_upd_en) st_q[snp_idx] <= snp_upd_st;
      case (fsm_q)
        FS_IDLE: begin
          if (accept) begin
            rq_we    <= cpu_we;
            rq_addr  <= cpu_addr;
            rq_wdata <= cpu_wdata;
            if (fast) begin
              cpu_ready <= 1'b1;
              cpu_rdata <= cpu_we ? cpu_wdata : rd_a;
              if (cpu_we) st_q[cpu_idx] <= ST_M;
            end else if (cur_st == ST_M && cur_tag != cpu_tag) begin
              bus_req   <= 1'b1;
              bus_cmd   <= CMD_WB;
              bus_addr  <= {cur_tag, cpu_idx};
              bus_wdata <= rd_a;
              fsm_q     <= FS_WBACK;
            end else begin
              bus_req  <= 1'b1;
              bus_cmd  <= cpu_we ? CMD_RDX : CMD_RD;
              bus_addr <= cpu_addr;
              fsm_q    <= FS_FETCH;
            end
          end
        end
        FS_WBACK: begin
          // a snoop may already have cleaned the victim: then skip the write-back
          if (bus_gnt || st_q[rq_idx] != ST_M) begin
            if (bus_gnt) st_q[rq_idx] <= ST_I;
            bus_cmd  <= rq_we ? CMD_RDX : CMD_RD;
            bus_addr <= rq_addr;
            fsm_q    <= FS_FETCH;
          end
        end
        FS_FETCH: begin
          if (bus_gnt) begin
            bus_req        <= 1'b0;
            bus_cmd        <= CMD_NONE;
            tag_q[rq_idx]  <= rq_tag;
            st_q[rq_idx]   <= rq_we ? ST_M : (bus_shared_in ? ST_S : ST_E);
            cpu_ready      <= 1'b1;
            cpu_rdata      <= rq_we ? rq_wdata : bus_rdata;
            fsm_q          <= FS_IDLE;
          end
        end
        default: fsm_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_shared,
  input logic              snp_flush,
  input logic              fsm_idle
);
  // completion is a single-cycle pulse
  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // no bus activity while the controller serves hits
  assert_idle_no_bus_R6: assert property (@(posedge clk) disable iff (rst)
    fsm_idle |-> !bus_req);

  // an ungranted read or read-exclusive request is held unchanged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && bus_cmd != 2'd3) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // completion and an open request never coincide
  assert_ready_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ready && bus_req));

  // shared only answers a snooped read
  assert_shared_src_R7: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> $past(snp_valid && snp_cmd == 2'd1));

  // data is only supplied in answer to a snoop
  assert_flush_src_R8: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> $past(snp_valid));

  // a granted write-back is followed by the fill request
  assert_wb_then_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd == 2'd3) |=> (bus_req && bus_cmd != 2'd3));
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ready  (cpu_ready),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_cmd    (bus_cmd),
  .bus_addr   (bus_addr),
  .snp_valid  (snp_valid),
  .snp_cmd    (snp_cmd),
  .snp_shared (snp_shared),
  .snp_flush  (snp_flush),
  .fsm_idle   (in_idle)
);

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic bus_gnt = 1'b0, bus_shared_in = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic snp_shared, snp_flush;
  logic [DATA_W-1:0] snp_data;

  int n_checks = 0;
  int n_err = 0;
  int log_n = 0;
  int wait_cnt = 0;
  logic [1:0]        log_cmd  [32];
  logic [ADDR_W-1:0] log_addr [32];
  logic [DATA_W-1:0] log_wd   [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(2), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
  );

  // bus model: grants each request after one waiting cycle and logs it
  always @(negedge clk) begin
    bus_gnt = 1'b0;
    if (bus_req && !rst) begin
      if (wait_cnt == 1) begin
        bus_gnt = 1'b1;
        if (log_n < 32) begin
          log_cmd[log_n]  = bus_cmd;
          log_addr[log_n] = bus_addr;
          log_wd[log_n]   = bus_wdata;
        end
        log_n++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_access(input logic we, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d, input logic shr,
                            input logic [DATA_W-1:0] fill,
                            output logic [DATA_W-1:0] rd, output int cyc);
    @(negedge clk);
    bus_shared_in = shr;
    bus_rdata = fill;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 100);
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a,
                       output logic sh, output logic fl, output logic [DATA_W-1:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'd0;
    sh = snp_shared; fl = snp_flush; d = snp_data;
  endtask

  task automatic t_reset;
    logic sh, fl; logic [DATA_W-1:0] d;
    check("R1", "cpu_ready after reset", int'(cpu_ready), 0);
    check("R1", "bus_req after reset", int'(bus_req), 0);
    snoop(2'd1, 8'h10, sh, fl, d);
    check("R1", "snoop shared on empty cache", int'(sh), 0);
    check("R1", "snoop flush on empty cache", int'(fl), 0);
  endtask

  task automatic t_exclusive_path;
    logic [DATA_W-1:0] rd, d; int cyc, base; logic sh, fl;
    base = log_n;
    cpu_access(1'b0, 8'h10, 8'h00, 1'b0, 8'hA1, rd, cyc);
    check("R3", "read miss bus count", log_n - base, 1);
    check("R3", "read miss cmd", int'(log_cmd[base]), 1);
    check("R3", "read miss addr", int'(log_addr[base]), 'h10);
    check("R3", "read miss data", int'(rd), 'hA1);
    base = log_n;
    cpu_access(1'b0, 8'h10, 8'h00, 1'b0, 8'h00, rd, cyc);
    check("R2", "read hit cycles", cyc, 1);
    check("R2", "read hit data", int'(rd), 'hA1);
    check("R2", "read hit no bus", log_n - base, 0);
    cpu_access(1'b1, 8'h10, 8'h55, 1'b0, 8'h00, rd, cyc);
    check("R6", "write to exclusive cycles", cyc, 1);
    check("R6", "write to exclusive no bus", log_n - base, 0);
    snoop(2'd1, 8'h10, sh, fl, d);
    check("R7", "modified snoop read shared", int'(sh), 1);
    check("R7", "modified snoop read flush", int'(fl), 1);
    check("R7", "modified snoop read data", int'(d), 'h55);
    snoop(2'd1, 8'h10, sh, fl, d);
    check("R7", "after downgrade shared", int'(sh), 1);
    check("R7", "after downgrade no flush", int'(fl), 0);
    base = log_n;
    cpu_access(1'b1, 8'h10, 8'h66, 1'b0, 8'hEE, rd, cyc);
    check("R5", "upgrade bus count", log_n - base, 1);
    check("R5", "upgrade cmd", int'(log_cmd[base]), 2);
    cpu_access(1'b0, 8'h10, 8'h00, 1'b0, 8'h00, rd, cyc);
    check("R5", "upgrade keeps written word", int'(rd), 'h66);
    check("R5", "read after upgrade is hit", cyc, 1);
  endtask

  task automatic t_shared_path;
    logic [DATA_W-1:0] rd, d; int cyc, base; logic sh, fl;
    cpu_access(1'b0, 8'h11, 8'h00, 1'b1, 8'hB2, rd, cyc);
    check("R3", "shared fill data", int'(rd), 'hB2);
    snoop(2'd1, 8'h11, sh, fl, d);
    check("R3", "shared fill snoop shared", int'(sh), 1);
    check("R3", "shared fill no flush", int'(fl), 0);
    snoop(2'd2, 8'h11, sh, fl, d);
    check("R8", "rdx on shared no shared", int'(sh), 0);
    check("R8", "rdx on shared no flush", int'(fl), 0);
    base = log_n;
    cpu_access(1'b0, 8'h11, 8'h00, 1'b0, 8'hB3, rd, cyc);
    check("R8", "invalidated line misses", log_n - base, 1);
    cpu_access(1'b0, 8'h13, 8'h00, 1'b0, 8'hC3, rd, cyc);
    snoop(2'd1, 8'h13, sh, fl, d);
    check("R7", "exclusive snoop shared", int'(sh), 1);
    check("R7", "exclusive snoop supplies", int'(fl), 1);
    check("R7", "exclusive snoop data", int'(d), 'hC3);
  endtask

  task automatic t_write_miss;
    logic [DATA_W-1:0] rd, d; int cyc, base; logic sh, fl;
    base = log_n;
    cpu_access(1'b1, 8'h21, 8'h77, 1'b0, 8'h00, rd, cyc);
    check("R4", "write miss bus count", log_n - base, 1);
    check("R4", "write miss cmd", int'(log_cmd[base]), 2);
    check("R4", "write miss addr", int'(log_addr[base]), 'h21);
    cpu_access(1'b0, 8'h21, 8'h00, 1'b0, 8'h00, rd, cyc);
    check("R4", "write miss data kept", int'(rd), 'h77);
    snoop(2'd2, 8'h21, sh, fl, d);
    check("R8", "rdx on modified no shared", int'(sh), 0);
    check("R8", "rdx on modified flush", int'(fl), 1);
    check("R8", "rdx on modified data", int'(d), 'h77);
    base = log_n;
    cpu_access(1'b0, 8'h21, 8'h00, 1'b0, 8'h99, rd, cyc);
    check("R8", "read after rdx misses", log_n - base, 1);
  endtask

  task automatic t_evict;
    logic [DATA_W-1:0] rd, d; int cyc, base; logic sh, fl;
    cpu_access(1'b1, 8'h22, 8'h44, 1'b0, 8'h00, rd, cyc);
    base = log_n;
    cpu_access(1'b0, 8'h42, 8'h00, 1'b0, 8'h5A, rd, cyc);
    check("R9", "dirty evict bus count", log_n - base, 2);
    check("R9", "write-back first", int'(log_cmd[base]), 3);
    check("R9", "write-back addr", int'(log_addr[base]), 'h22);
    check("R9", "write-back data", int'(log_wd[base]), 'h44);
    check("R9", "fill after write-back", int'(log_cmd[base+1]), 1);
    check("R9", "fill addr", int'(log_addr[base+1]), 'h42);
    check("R9", "fill data", int'(rd), 'h5A);
    snoop(2'd1, 8'h22, sh, fl, d);
    check("R10", "old tag snoop no shared", int'(sh), 0);
    check("R10", "old tag snoop no flush", int'(fl), 0);
    base = log_n;
    cpu_access(1'b0, 8'h82, 8'h00, 1'b0, 8'h6B, rd, cyc);
    check("R9", "clean evict single request", log_n - base, 1);
    check("R9", "clean evict cmd", int'(log_cmd[base]), 1);
    snoop(2'd2, 8'h03, sh, fl, d);
    check("R10", "snoop tag mismatch no flush", int'(fl), 0);
    snoop(2'd1, 8'h13, sh, fl, d);
    check("R10", "mismatch left line valid", int'(sh), 1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_exclusive_path();
    t_shared_path();
    t_write_miss();
    t_evict();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule